// File: doc/BRIEF.md
# Flash Write-Protection Range Checker

This block sits between the host request path and the serial flash command sequencer and rules on every flash cycle before it reaches the pins. Each request carries a 24-bit flash address and a class flag. The flag says whether the opcode belongs to the modifying class, meaning it needs a write-enable style prefix (program, erase, status write). One clock after the request the block raises a verdict of allow or block. A blocked cycle also sets a sticky status flag. The sequencer issues a cycle on the pins only when the verdict is allow. The one-clock delay is there so the verdict is stable before chip select is driven.

The policy comes from three sources. The first is a small bank of protected windows, each with an enable, a first page and a last page, counted in 4 KiB pages. The second is a boot-region floor: a byte address below which no cycle of any class may run. The third is a configuration lock. Once the lock is set it freezes the windows and the floor until the next reset. It is also exported so that the opcode and prefix tables elsewhere can be frozen with the same bit.

Top module: `flash_guard`

## Requirements
- R1: After synchronous reset, dec_valid, dec_allow, dec_block, blk_flag and cfg_locked are 0, every window is disabled and the floor is 0, so every request is allowed.
- R2: A request sampled with req_valid=1 at a clock edge produces dec_valid=1 after the next edge and at no other time. The verdict uses the configuration held before that edge, not a write made in the same cycle.
- R3: A modifying request (req_needs_prefix=1) is blocked when its page req_addr[23:12] satisfies first <= page <= last for any enabled window. Both ends are inclusive.
- R4: A read-class request (req_needs_prefix=0) is never blocked by a window, even one that covers its page.
- R5: A window whose enable bit is 0 blocks nothing, whatever its page fields hold.
- R6: Any request whose byte address is strictly below the floor is blocked, whatever its class. A request at exactly the floor address is not blocked by the floor.
- R7: blk_flag is set in the same cycle as each dec_block=1 and stays set. A write to the status select with bit 0 = 1 clears it. A write with bit 0 = 0 has no effect. A block and a clear in the same cycle leave the flag set.
- R8: A write to the control select with bit 0 = 1 sets cfg_locked. Writing 0 has no effect, and only reset clears the lock. While locked, writes to windows and to the floor are ignored.
- R9: While dec_valid=1, exactly one of dec_allow and dec_block is 1. While dec_valid=0, both are 0.
- R10: The status clear of R7 still works while the configuration is locked.
- R11: cfg_sel encoding with the default three windows: 0 to 2 select window 0 to 2, 3 the floor, 4 control, 5 status. A window word holds the enable at bit 31, the last page at bits [23:12] and the first page at bits [11:0]. The floor takes the byte address from bits [23:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | A flash cycle is requested this clock |
| req_needs_prefix | input | 1 | The opcode is of the modifying class |
| req_addr | input | 24 | Flash byte address of the cycle |
| dec_valid | output | 1 | A verdict is presented |
| dec_allow | output | 1 | The cycle may be issued |
| dec_block | output | 1 | The cycle must be dropped |
| blk_flag | output | 1 | Sticky blocked-access status |
| cfg_locked | output | 1 | Configuration lock state |

## Verification
The assertions assume that req_valid, req_needs_prefix, req_addr and the configuration inputs are sampled only at clock edges, and that a configuration write and a request may share a cycle. They also assume that the class flag is correct for the opcode, since the block trusts the flag as given. The stimulus drives every input on the falling edge and holds it through the next rising edge. It keeps each request within the 24-bit address space. It sweeps every page with both classes under three configurations: windows only, windows plus floor, and a locked configuration after rejected rewrites. The expected verdicts come from a shadow of the writes that the requirements say should take effect.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [2:0] {
    RK_RANGE,
    RK_BOOT,
    RK_CTRL,
    RK_STAT,
    RK_NONE
  } reg_kind_e;

  localparam int LOCK_BIT = 0;
  localparam int CLR_BIT  = 0;

  // Select map: windows first, then floor, control, status.
  function automatic reg_kind_e kind_of(input int unsigned sel, input int unsigned n_rng);
    if (sel < n_rng)          return RK_RANGE;
    else if (sel == n_rng)     return RK_BOOT;
    else if (sel == n_rng + 1) return RK_CTRL;
    else if (sel == n_rng + 2) return RK_STAT;
    else                       return RK_NONE;
  endfunction

endpackage

// File: rtl/fg_cfg_regs.sv
module fg_cfg_regs
  import flash_guard_pkg::*;
#(
  parameter int N_RANGE  = 3,
  parameter int ADDR_W   = 24,
  parameter int PG_SHIFT = 12,
  parameter int DATA_W   = 32,
  parameter int SEL_W    = 3,
  localparam int PG_W    = ADDR_W - PG_SHIFT
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic [SEL_W-1:0]               cfg_sel,
  input  logic [DATA_W-1:0]              cfg_wdata,
  output logic [N_RANGE-1:0]             rng_en,
  output logic [N_RANGE-1:0][PG_W-1:0]   rng_lo,
  output logic [N_RANGE-1:0][PG_W-1:0]   rng_hi,
  output logic [ADDR_W-1:0]              boot_base,
  output logic                           locked,
  output logic                           stat_clr
);

  reg_kind_e kind;
  logic      wr_open;
  logic      unused_bits;

  assign kind        = kind_of(32'(cfg_sel), N_RANGE);
  assign wr_open     = cfg_we && !locked;
  assign stat_clr    = cfg_we && (kind == RK_STAT) && cfg_wdata[CLR_BIT];
  assign unused_bits = ^cfg_wdata;

  for (genvar g = 0; g < N_RANGE; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        rng_en[g] <= 1'b0;
        rng_lo[g] <= '0;
        rng_hi[g] <= '0;
      end else if (wr_open && (kind == RK_RANGE) && (cfg_sel == SEL_W'(g))) begin
        rng_en[g] <= cfg_wdata[DATA_W-1];
        rng_hi[g] <= cfg_wdata[2*PG_W-1:PG_W];
        rng_lo[g] <= cfg_wdata[PG_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      boot_base <= '0;
    else if (wr_open && (kind == RK_BOOT))
      boot_base <= cfg_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      locked <= 1'b0;
    else if (cfg_we && (kind == RK_CTRL) && cfg_wdata[LOCK_BIT])
      locked <= 1'b1;
  end

endmodule

// File: rtl/fg_range_match.sv
module fg_range_match #(
  parameter int PG_W = 12
) (
  input  logic            en,
  input  logic [PG_W-1:0] lo,
  input  logic [PG_W-1:0] hi,
  input  logic [PG_W-1:0] pg,
  output logic            hit
);

  // Both window ends are inclusive.
  assign hit = en && (pg >= lo) && (pg <= hi);

endmodule

// File: rtl/fg_verdict.sv
module fg_verdict (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_needs_prefix,
  input  logic below_boot,
  input  logic range_hit,
  input  logic stat_clr,
  output logic dec_valid,
  output logic dec_allow,
  output logic dec_block,
  output logic blk_flag
);

  logic deny;

  assign deny = below_boot || (req_needs_prefix && range_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_allow <= 1'b0;
      dec_block <= 1'b0;
      blk_flag  <= 1'b0;
    end else begin
      dec_valid <= req_valid;
      dec_allow <= req_valid && !deny;
      dec_block <= req_valid && deny;
      if (req_valid && deny)
        blk_flag <= 1'b1;
      else if (stat_clr)
        blk_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int N_RANGE  = 3,
  parameter int ADDR_W   = 24,
  parameter int PG_SHIFT = 12,
  parameter int DATA_W   = 32,
  localparam int PG_W    = ADDR_W - PG_SHIFT,
  localparam int SEL_W   = $clog2(N_RANGE + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic              req_needs_prefix,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              dec_valid,
  output logic              dec_allow,
  output logic              dec_block,
  output logic              blk_flag,
  output logic              cfg_locked
);

  logic [N_RANGE-1:0]           rng_en;
  logic [N_RANGE-1:0][PG_W-1:0] rng_lo;
  logic [N_RANGE-1:0][PG_W-1:0] rng_hi;
  logic [ADDR_W-1:0]            boot_base;
  logic                         stat_clr;
  logic [N_RANGE-1:0]           hits;
  logic                         range_hit;
  logic                         below_boot;

  fg_cfg_regs #(
    .N_RANGE (N_RANGE),
    .ADDR_W  (ADDR_W),
    .PG_SHIFT(PG_SHIFT),
    .DATA_W  (DATA_W),
    .SEL_W   (SEL_W)
  ) cfg_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .rng_en   (rng_en),
    .rng_lo   (rng_lo),
    .rng_hi   (rng_hi),
    .boot_base(boot_base),
    .locked   (cfg_locked),
    .stat_clr (stat_clr)
  );

  for (genvar g = 0; g < N_RANGE; g++) begin : g_match
    fg_range_match #(.PG_W(PG_W)) match_i (
      .en (rng_en[g]),
      .lo (rng_lo[g]),
      .hi (rng_hi[g]),
      .pg (req_addr[ADDR_W-1:PG_SHIFT]),
      .hit(hits[g])
    );
  end

  assign range_hit  = |hits;
  assign below_boot = req_addr < boot_base;

  fg_verdict verdict_i (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_needs_prefix(req_needs_prefix),
    .below_boot      (below_boot),
    .range_hit       (range_hit),
    .stat_clr        (stat_clr),
    .dec_valid       (dec_valid),
    .dec_allow       (dec_allow),
    .dec_block       (dec_block),
    .blk_flag        (blk_flag)
  );

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int N_RANGE = 3,
  parameter int ADDR_W  = 24
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_needs_prefix,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               dec_valid,
  input logic               dec_allow,
  input logic               dec_block,
  input logic               blk_flag,
  input logic               cfg_locked,
  input logic [ADDR_W-1:0]  boot_base,
  input logic [N_RANGE-1:0] rng_en,
  input logic               stat_clr
);

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!dec_valid && !blk_flag && !cfg_locked));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_valid);

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !dec_valid);

  assert_read_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_needs_prefix && !(req_addr < boot_base)) |=> dec_allow);

  assert_no_enable_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (rng_en == '0) && !(req_addr < boot_base)) |=> dec_allow);

  assert_below_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_addr < boot_base)) |=> dec_block);

  assert_flag_follows_R7: assert property (@(posedge clk) disable iff (rst)
    dec_block |-> blk_flag);

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (blk_flag && !stat_clr) |=> blk_flag);

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_locked |=> cfg_locked);

  assert_floor_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_locked |=> $stable(boot_base));

  assert_windows_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_locked |=> $stable(rng_en));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_allow != dec_block));

  assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!dec_allow && !dec_block));

endmodule

bind flash_guard flash_guard_chk #(
  .N_RANGE(N_RANGE),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk             (clk),
  .rst             (rst),
  .req_valid       (req_valid),
  .req_needs_prefix(req_needs_prefix),
  .req_addr        (req_addr),
  .dec_valid       (dec_valid),
  .dec_allow       (dec_allow),
  .dec_block       (dec_block),
  .blk_flag        (blk_flag),
  .cfg_locked      (cfg_locked),
  .boot_base       (boot_base),
  .rng_en          (rng_en),
  .stat_clr        (stat_clr)
);

// File: tb/flash_guard_tb_top.sv
`timescale 1ns/1ps
module flash_guard_tb_top;

  localparam int NR = 3;
  localparam logic [2:0] SEL_FLOOR = 3'd3;
  localparam logic [2:0] SEL_CTRL  = 3'd4;
  localparam logic [2:0] SEL_STAT  = 3'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_needs_prefix = 1'b0;
  logic [23:0] req_addr = '0;
  logic        dec_valid, dec_allow, dec_block, blk_flag, cfg_locked;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Shadow of the configuration the requirements say is in effect.
  bit          sh_en [NR];
  logic [11:0] sh_lo [NR];
  logic [11:0] sh_hi [NR];
  logic [23:0] sh_floor;
  bit          sh_lock;

  always #5 clk = ~clk;

  flash_guard dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_needs_prefix(req_needs_prefix), .req_addr(req_addr),
    .dec_valid(dec_valid), .dec_allow(dec_allow), .dec_block(dec_block),
    .blk_flag(blk_flag), .cfg_locked(cfg_locked)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic shadow_reset();
    for (int i = 0; i < NR; i++) begin
      sh_en[i] = 0; sh_lo[i] = '0; sh_hi[i] = '0;
    end
    sh_floor = '0;
    sh_lock  = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    shadow_reset();
    @(negedge clk);
  endtask

  // All tasks start and end on a falling edge.
  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!sh_lock) begin
      if (sel < NR) begin
        sh_en[sel] = data[31]; sh_hi[sel] = data[23:12]; sh_lo[sel] = data[11:0];
      end else if (sel == SEL_FLOOR) begin
        sh_floor = data[23:0];
      end
    end
    if (sel == SEL_CTRL && data[0]) sh_lock = 1;
  endtask

  task automatic wr_window(input int idx, input bit en, input logic [11:0] lo, input logic [11:0] hi);
    cfg_write(3'(idx), {en, 7'd0, hi, lo});
  endtask

  function automatic bit exp_block(input bit pref, input logic [23:0] a, output string tag);
    bit in_win = 0;
    for (int i = 0; i < NR; i++)
      if (sh_en[i] && a[23:12] >= sh_lo[i] && a[23:12] <= sh_hi[i]) in_win = 1;
    if (a < sh_floor) begin tag = "R6 floor"; return 1; end
    if (pref && in_win) begin tag = "R3 window"; return 1; end
    if (!pref && in_win) tag = "R4 read in window";
    else tag = "R5/R2 outside windows";
    return 0;
  endfunction

  task automatic do_req(input bit pref, input logic [23:0] a);
    string tag;
    bit    eb;
    eb = exp_block(pref, a, tag);
    req_valid = 1'b1; req_needs_prefix = pref; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(dec_valid && dec_block == eb && dec_allow == !eb && (!eb || blk_flag),
          $sformatf("%s R9 addr=%06h pref=%0d", tag, a, pref),
          {28'd0, dec_valid, dec_allow, dec_block, blk_flag},
          {28'd0, 1'b1, !eb, eb, 1'b1});
  endtask

  task automatic sweep();
    for (int pg = 0; pg < 4096; pg++)
      for (int t = 0; t < 2; t++)
        do_req(t[0], {12'(pg), 12'(pg * 37 + t * 1000)});
  endtask

  initial begin
    #(10ns * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    shadow_reset();
    @(negedge clk);
    do_reset();

    // R1: reset state, open configuration
    check({dec_valid, dec_allow, dec_block, blk_flag, cfg_locked} == 5'b0, "R1 reset outputs",
          {27'd0, dec_valid, dec_allow, dec_block, blk_flag, cfg_locked}, 32'd0);
    @(negedge clk);
    check(!dec_valid, "R2 no verdict without request", {31'd0, dec_valid}, 32'd0);
    do_req(1'b1, 24'hFFFFFF);
    check(dec_allow, "R1 open after reset", {31'd0, dec_allow}, 32'd1);

    // Windows only (R3, R4, R5, R11)
    wr_window(0, 1'b1, 12'h010, 12'h01F);
    wr_window(1, 1'b0, 12'h100, 12'h1FF);
    wr_window(2, 1'b1, 12'h800, 12'h800);
    sweep();

    // R7: sticky flag, write 0 no effect, write 1 clears
    check(blk_flag, "R7 flag after blocks", {31'd0, blk_flag}, 32'd1);
    cfg_write(SEL_STAT, 32'h0000_0000);
    check(blk_flag, "R7 write 0 keeps flag", {31'd0, blk_flag}, 32'd1);
    cfg_write(SEL_STAT, 32'h0000_0001);
    check(!blk_flag, "R7 write 1 clears flag", {31'd0, blk_flag}, 32'd0);
    do_req(1'b0, 24'h010000);
    check(!blk_flag, "R4 read does not set flag", {31'd0, blk_flag}, 32'd0);

    // R7: block and clear in the same cycle, block wins
    req_valid = 1'b1; req_needs_prefix = 1'b1; req_addr = 24'h01F123;
    cfg_we = 1'b1; cfg_sel = SEL_STAT; cfg_wdata = 32'h1;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    check(blk_flag && dec_block, "R7 set wins over clear",
          {30'd0, blk_flag, dec_block}, 32'd3);
    cfg_write(SEL_STAT, 32'h1);

    // R2: a write in the same cycle as a request does not affect it
    req_valid = 1'b1; req_needs_prefix = 1'b1; req_addr = 24'h400000;
    cfg_we = 1'b1; cfg_sel = 3'd1; cfg_wdata = {1'b1, 7'd0, 12'h400, 12'h400};
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    sh_en[1] = 1; sh_lo[1] = 12'h400; sh_hi[1] = 12'h400;
    check(dec_allow, "R2 verdict uses prior config", {31'd0, dec_allow}, 32'd1);
    do_req(1'b1, 24'h400000);

    // Floor (R6): byte-exact boundary then full sweep
    cfg_write(SEL_FLOOR, 32'hFF02_0000);
    do_req(1'b0, 24'h01FFFF);
    do_req(1'b0, 24'h020000);
    do_req(1'b1, 24'h000000);
    sweep();
    cfg_write(SEL_STAT, 32'h1);

    // Lock (R8, R10)
    cfg_write(SEL_CTRL, 32'h0);
    check(!cfg_locked, "R8 write 0 does not lock", {31'd0, cfg_locked}, 32'd0);
    cfg_write(SEL_CTRL, 32'h1);
    check(cfg_locked, "R8 lock set", {31'd0, cfg_locked}, 32'd1);
    wr_window(0, 1'b0, 12'h000, 12'h000);
    wr_window(1, 1'b1, 12'h100, 12'h1FF);
    cfg_write(SEL_FLOOR, 32'h0);
    cfg_write(SEL_CTRL, 32'h0);
    check(cfg_locked, "R8 lock sticky", {31'd0, cfg_locked}, 32'd1);
    sweep();
    check(blk_flag, "R10 flag set before clear", {31'd0, blk_flag}, 32'd1);
    cfg_write(SEL_STAT, 32'h1);
    check(!blk_flag, "R10 clear while locked", {31'd0, blk_flag}, 32'd0);

    // R8/R1: only reset releases the lock
    do_reset();
    check(!cfg_locked, "R8 reset releases lock", {31'd0, cfg_locked}, 32'd0);
    do_req(1'b1, 24'h010000);
    check(dec_allow, "R1 config cleared by reset", {31'd0, dec_allow}, 32'd1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule